// File: doc/BRIEF.md
# Palette DAC Write Sequencer

This block accepts colour palette updates through a VGA-style DAC port pair. A write to the index port selects the palette entry to be written. Each write to the data port then supplies one colour component, in the fixed order red, green, blue. The red and green values are held in latches. The blue write stores the complete triple into a 256-entry palette RAM and moves the index on by one, so a program can stream consecutive entries without reloading the index.

Two attribute-controller control bytes can block palette updates. While either inhibit bit is set, a data write updates neither a latch nor the RAM, but the component phase and the index still advance exactly as for a normal write. Incoming bytes can first be shifted left by two positions. A mode input selects 6-bit or 8-bit component storage. A separate lookup port returns the 24-bit colour of any entry one cycle later. In 6-bit mode it expands each component to 8 bits.

Top module: `pal_dac_wr`

## Requirements
- R1: After reset, `wr_index` is 0, `wr_phase` is 0 (red) and `lk_rgb` is 0.
- R2: An `idx_wr` pulse loads `idx_data` into the write index and returns the phase to red on the next edge. If `dat_wr` is high in the same cycle, the data write is ignored: no latch changes, no commit happens and the index does not advance.
- R3: Each accepted data write steps `wr_phase` through the encodings 0 (red), 1 (green), 2 (blue) and then back to 0. The value 3 never appears.
- R4: The write at phase 2 stores {red latch, green latch, incoming blue} into the entry at the current index. In the same edge, the index increases by one modulo 256. Writes at phases 0 and 1 leave the index unchanged.
- R5: When bit 1 of `attr_ctl_a` or bit 7 of `attr_ctl_b` is set, a data write changes no latch and commits nothing. The phase and index still advance as in R3 and R4.
- R6: With `mode8` low, a component is masked to its low 6 bits when latched. The lookup returns each 6-bit value c as {c[5:0], c[5:4]}.
- R7: With `mode8` high, components are stored and returned as full 8-bit values.
- R8: With `shift_en` high, each data byte is shifted left by two (the top bits are dropped) before the R6/R7 handling.
- R9: `lk_rgb` shows the entry addressed by `lk_addr` one edge later, packed as red [23:16], green [15:8], blue [7:0]. The expansion follows the `mode8` value of the lookup cycle. A commit to the same entry in that cycle is returned with its new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| idx_wr | input | 1 | Write-index port strobe |
| idx_data | input | 8 | Index value to load |
| dat_wr | input | 1 | Data port strobe, one component per pulse |
| dat_in | input | 8 | Component data byte |
| mode8 | input | 1 | 1: 8-bit components, 0: 6-bit components |
| shift_en | input | 1 | Shift each data byte left by two |
| attr_ctl_a | input | 8 | Attribute control byte, bit 1 inhibits commits |
| attr_ctl_b | input | 8 | Attribute control byte, bit 7 inhibits commits |
| lk_addr | input | 8 | Lookup entry address |
| lk_rgb | output | 24 | Looked-up colour, registered |
| wr_index | output | 8 | Current write index |
| wr_phase | output | 2 | Current component phase |

## Verification
Two pairs of events can fall in the same cycle. The first is an index load together with a data write. The second is a blue commit together with a lookup of the entry being committed. The bench provokes both, with directed cases and with random stimulus that raises both strobes at once and that often points `lk_addr` at the current write index. In the first case, the index and phase must show only the load and the palette model must stay untouched. In the second case, `lk_rgb` on the following cycle must already show the freshly committed triple.

// File: rtl/pal_dac_pkg.sv
package pal_dac_pkg;
    localparam int COMP_W = 8;
    localparam int RGB_W  = 3 * COMP_W;

    typedef enum logic [1:0] {
        PH_RED = 2'd0,
        PH_GRN = 2'd1,
        PH_BLU = 2'd2
    } phase_e;

    // Widen a 6-bit component to 8 bits by repeating its top two bits.
    function automatic logic [COMP_W-1:0] widen6(input logic [COMP_W-1:0] c);
        return {c[5:0], c[5:4]};
    endfunction
endpackage

// File: rtl/pal_dac_seq.sv
module pal_dac_seq
    import pal_dac_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                idx_wr,
    input  logic [IDX_W-1:0]    idx_data,
    input  logic                dat_wr,
    input  logic [COMP_W-1:0]   comp_in,
    input  logic                inhibit,
    output logic [IDX_W-1:0]    index,
    output phase_e              phase,
    output logic                commit_we,
    output logic [IDX_W-1:0]    commit_addr,
    output logic [RGB_W-1:0]    commit_rgb
);
    typedef struct packed {
        logic [IDX_W-1:0]  idx;
        phase_e            ph;
        logic [COMP_W-1:0] red;
        logic [COMP_W-1:0] grn;
    } seq_t;

    seq_t st_d, st_q;
    logic we_d;

    always_comb begin
        st_d = st_q;
        we_d = 1'b0;
        if (idx_wr) begin
            st_d.idx = idx_data;
            st_d.ph  = PH_RED;
        end else if (dat_wr) begin
            case (st_q.ph)
                PH_RED: begin
                    if (!inhibit) st_d.red = comp_in;
                    st_d.ph = PH_GRN;
                end
                PH_GRN: begin
                    if (!inhibit) st_d.grn = comp_in;
                    st_d.ph = PH_BLU;
                end
                default: begin
                    we_d     = !inhibit;
                    st_d.ph  = PH_RED;
                    st_d.idx = st_q.idx + 1'b1;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{idx: '0, ph: PH_RED, red: '0, grn: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign index       = st_q.idx;
    assign phase       = st_q.ph;
    assign commit_we   = we_d;
    assign commit_addr = st_q.idx;
    assign commit_rgb  = {st_q.red, st_q.grn, comp_in};
endmodule

// File: rtl/pal_dac_ram.sv
module pal_dac_ram
    import pal_dac_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                we,
    input  logic [IDX_W-1:0]    waddr,
    input  logic [RGB_W-1:0]    wdata,
    input  logic [IDX_W-1:0]    raddr,
    input  logic                mode8,
    output logic [RGB_W-1:0]    rdata
);
    localparam int DEPTH = 1 << IDX_W;

    logic [RGB_W-1:0] mem [DEPTH];
    logic [RGB_W-1:0] raw;
    logic [RGB_W-1:0] out_d, out_q;

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    // Write-through when the looked-up entry is committed in this cycle.
    assign raw = (we && (waddr == raddr)) ? wdata : mem[raddr];

    for (genvar k = 0; k < 3; k++) begin : g_comp
        always_comb begin
            out_d[k*COMP_W +: COMP_W] = mode8 ? raw[k*COMP_W +: COMP_W]
                                              : widen6(raw[k*COMP_W +: COMP_W]);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign rdata = out_q;
endmodule

// File: rtl/pal_dac_wr.sv
module pal_dac_wr
    import pal_dac_pkg::*;
#(
    parameter int IDX_W     = 8,
    parameter int INH_A_BIT = 1,
    parameter int INH_B_BIT = 7
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                idx_wr,
    input  logic [IDX_W-1:0]    idx_data,
    input  logic                dat_wr,
    input  logic [COMP_W-1:0]   dat_in,
    input  logic                mode8,
    input  logic                shift_en,
    input  logic [7:0]          attr_ctl_a,
    input  logic [7:0]          attr_ctl_b,
    input  logic [IDX_W-1:0]    lk_addr,
    output logic [RGB_W-1:0]    lk_rgb,
    output logic [IDX_W-1:0]    wr_index,
    output logic [1:0]          wr_phase
);
    logic [COMP_W-1:0] shifted, comp;
    logic              inhibit;
    logic              c_we;
    logic [IDX_W-1:0]  c_addr;
    logic [RGB_W-1:0]  c_rgb;
    phase_e            ph;

    assign shifted = shift_en ? {dat_in[COMP_W-3:0], 2'b00} : dat_in;
    assign comp    = mode8 ? shifted : {2'b00, shifted[5:0]};
    assign inhibit = attr_ctl_a[INH_A_BIT] | attr_ctl_b[INH_B_BIT];

    pal_dac_seq #(.IDX_W(IDX_W)) u_seq (
        .clk(clk), .rst_n(rst_n),
        .idx_wr(idx_wr), .idx_data(idx_data),
        .dat_wr(dat_wr), .comp_in(comp), .inhibit(inhibit),
        .index(wr_index), .phase(ph),
        .commit_we(c_we), .commit_addr(c_addr), .commit_rgb(c_rgb)
    );

    pal_dac_ram #(.IDX_W(IDX_W)) u_ram (
        .clk(clk), .rst_n(rst_n),
        .we(c_we), .waddr(c_addr), .wdata(c_rgb),
        .raddr(lk_addr), .mode8(mode8), .rdata(lk_rgb)
    );

    assign wr_phase = ph;
endmodule

// File: rtl/pal_dac_chk.sv
module pal_dac_chk #(
    parameter int IDX_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             idx_wr,
    input logic [IDX_W-1:0] idx_data,
    input logic             dat_wr,
    input logic [IDX_W-1:0] wr_index,
    input logic [1:0]       wr_phase
);
    // R2
    idx_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        idx_wr |=> (wr_index == $past(idx_data)) && (wr_phase == 2'd0));

    // R3
    phase_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_phase != 2'd3);

    // R3
    phase_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_wr && !idx_wr) |=>
            wr_phase == (($past(wr_phase) == 2'd2) ? 2'd0 : $past(wr_phase) + 2'd1));

    // R4
    index_bump_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_wr && !idx_wr && wr_phase == 2'd2) |=> wr_index == $past(wr_index) + 1'b1);

    // R4
    index_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!idx_wr && !(dat_wr && wr_phase == 2'd2)) |=> $stable(wr_index));
endmodule

bind pal_dac_wr pal_dac_chk #(.IDX_W(IDX_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .idx_wr(idx_wr), .idx_data(idx_data),
    .dat_wr(dat_wr), .wr_index(wr_index), .wr_phase(wr_phase)
);

// File: tb/tb_pal_dac_wr.sv
`timescale 1ns/1ps
module tb_pal_dac_wr;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        idx_wr = 1'b0;
    logic [7:0]  idx_data = '0;
    logic        dat_wr = 1'b0;
    logic [7:0]  dat_in = '0;
    logic        mode8 = 1'b1;
    logic        shift_en = 1'b0;
    logic [7:0]  attr_ctl_a = '0;
    logic [7:0]  attr_ctl_b = '0;
    logic [7:0]  lk_addr = '0;
    logic [23:0] lk_rgb;
    logic [7:0]  wr_index;
    logic [1:0]  wr_phase;

    always #10 clk = ~clk;

    pal_dac_wr dut (
        .clk(clk), .rst_n(rst_n), .idx_wr(idx_wr), .idx_data(idx_data),
        .dat_wr(dat_wr), .dat_in(dat_in), .mode8(mode8), .shift_en(shift_en),
        .attr_ctl_a(attr_ctl_a), .attr_ctl_b(attr_ctl_b), .lk_addr(lk_addr),
        .lk_rgb(lk_rgb), .wr_index(wr_index), .wr_phase(wr_phase)
    );

    int total = 0;
    int bad = 0;
    bit done = 0;

    logic [23:0] pal_m [256];
    logic [7:0]  m_idx = '0;
    logic [1:0]  m_ph = '0;
    logic [7:0]  m_r = '0, m_g = '0;

    function automatic logic [7:0] cond(input logic [7:0] d, input logic m8, input logic sh);
        logic [7:0] v;
        v = sh ? (d << 2) : d;
        return m8 ? v : (v & 8'h3f);
    endfunction

    function automatic logic [23:0] view(input logic [23:0] e, input logic m8);
        logic [23:0] o;
        for (int k = 0; k < 3; k++) begin
            logic [7:0] c;
            c = e[k*8 +: 8];
            o[k*8 +: 8] = m8 ? c : {c[5:0], c[5:4]};
        end
        return o;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // One cycle of stimulus, driven at negedge, checked at the next negedge.
    task automatic op(input logic iw, input logic [7:0] iv, input logic dw,
                      input logic [7:0] dv, input logic [7:0] la, input bit lk_chk,
                      input string tag);
        logic inh;
        idx_wr = iw; idx_data = iv; dat_wr = dw; dat_in = dv; lk_addr = la;
        inh = attr_ctl_a[1] | attr_ctl_b[7];
        if (iw) begin
            m_idx = iv; m_ph = 2'd0;
        end else if (dw) begin
            case (m_ph)
                2'd0: begin if (!inh) m_r = cond(dv, mode8, shift_en); m_ph = 2'd1; end
                2'd1: begin if (!inh) m_g = cond(dv, mode8, shift_en); m_ph = 2'd2; end
                default: begin
                    if (!inh) pal_m[m_idx] = {m_r, m_g, cond(dv, mode8, shift_en)};
                    m_ph = 2'd0; m_idx = m_idx + 8'd1;
                end
            endcase
        end
        @(posedge clk);
        @(negedge clk);
        idx_wr = 1'b0; dat_wr = 1'b0;
        chk({tag, " index"}, {24'd0, wr_index}, {24'd0, m_idx});
        chk({tag, " phase"}, {30'd0, wr_phase}, {30'd0, m_ph});
        if (lk_chk) chk({tag, " lookup"}, {8'd0, lk_rgb}, {8'd0, view(pal_m[la], mode8)});
    endtask

    task automatic lookup(input logic [7:0] a, input string tag);
        op(1'b0, 8'd0, 1'b0, 8'd0, a, 1'b1, tag);
    endtask

    initial begin
        int cyc;
        cyc = 0;
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000 && !done) begin
                done = 1;
                total++; bad++;
                $display("FAIL watchdog actual=%0d expected<150000", cyc);
                $display("  test done: total=%0d bad=%0d", total, bad);
                $finish;
            end
        end
    end

    initial begin
        logic [23:0] keep;
        void'($urandom(32'h5eed_0b1e));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk("R1 index", {24'd0, wr_index}, 32'd0);
        chk("R1 phase", {30'd0, wr_phase}, 32'd0);
        chk("R1 lookup", {8'd0, lk_rgb}, 32'd0);

        // Fill the whole palette in 8-bit mode (R4 streaming through wrap).
        for (int i = 0; i < 768; i++)
            op(1'b0, 8'd0, 1'b1, 8'($urandom), 8'd0, 1'b0, "R4 fill");
        lookup(8'd0, "R4 fill entry0");
        lookup(8'd255, "R4 fill entry255");

        // R7 direct 8-bit values
        op(1'b1, 8'd40, 1'b0, 8'd0, 8'd0, 1'b0, "R2 load");
        op(1'b0, 8'd0, 1'b1, 8'hDE, 8'd0, 1'b0, "R7 red");
        op(1'b0, 8'd0, 1'b1, 8'hAD, 8'd0, 1'b0, "R7 grn");
        op(1'b0, 8'd0, 1'b1, 8'hBE, 8'd0, 1'b0, "R7 blu");
        lookup(8'd40, "R7 entry");
        chk("R7 value", {8'd0, lk_rgb}, 32'h00DEADBE);

        // R6 6-bit mask and widen: C5->05->14, 3F->FF, 20->82
        mode8 = 1'b0;
        op(1'b1, 8'd41, 1'b0, 8'd0, 8'd0, 1'b0, "R2 load");
        op(1'b0, 8'd0, 1'b1, 8'hC5, 8'd0, 1'b0, "R6 red");
        op(1'b0, 8'd0, 1'b1, 8'h3F, 8'd0, 1'b0, "R6 grn");
        op(1'b0, 8'd0, 1'b1, 8'h20, 8'd0, 1'b0, "R6 blu");
        lookup(8'd41, "R6 entry");
        chk("R6 value", {8'd0, lk_rgb}, 32'h0014FF82);

        // R8 shift in 8-bit mode: 31->C4, FF->FC, 01->04
        mode8 = 1'b1; shift_en = 1'b1;
        op(1'b1, 8'd42, 1'b0, 8'd0, 8'd0, 1'b0, "R2 load");
        op(1'b0, 8'd0, 1'b1, 8'h31, 8'd0, 1'b0, "R8 red");
        op(1'b0, 8'd0, 1'b1, 8'hFF, 8'd0, 1'b0, "R8 grn");
        op(1'b0, 8'd0, 1'b1, 8'h01, 8'd0, 1'b0, "R8 blu");
        lookup(8'd42, "R8 entry");
        chk("R8 value", {8'd0, lk_rgb}, 32'h00C4FC04);
        shift_en = 1'b0;

        // R5 inhibit via each control bit: entry kept, index still moves
        lookup(8'd20, "R5 before");
        keep = lk_rgb;
        attr_ctl_a = 8'h02;
        op(1'b1, 8'd20, 1'b0, 8'd0, 8'd0, 1'b0, "R2 load");
        for (int i = 0; i < 3; i++)
            op(1'b0, 8'd0, 1'b1, 8'h11, 8'd20, 1'b1, "R5 inhibit a");
        chk("R5 index moved", {24'd0, wr_index}, 32'd21);
        attr_ctl_a = 8'hFD; attr_ctl_b = 8'h80;
        op(1'b1, 8'd20, 1'b0, 8'd0, 8'd0, 1'b0, "R2 load");
        for (int i = 0; i < 3; i++)
            op(1'b0, 8'd0, 1'b1, 8'h22, 8'd20, 1'b1, "R5 inhibit b");
        attr_ctl_a = 8'h00; attr_ctl_b = 8'h7F;
        lookup(8'd20, "R5 after");
        chk("R5 entry unchanged", {8'd0, lk_rgb}, {8'd0, keep});
        attr_ctl_b = 8'h00;

        // R2 simultaneous load and data write: data ignored
        op(1'b1, 8'd60, 1'b0, 8'd0, 8'd0, 1'b0, "R2 load");
        op(1'b0, 8'd0, 1'b1, 8'h10, 8'd0, 1'b0, "R2 red");
        op(1'b0, 8'd0, 1'b1, 8'h20, 8'd0, 1'b0, "R2 grn");
        op(1'b1, 8'd61, 1'b1, 8'h30, 8'd60, 1'b1, "R2 both");
        chk("R2 index", {24'd0, wr_index}, 32'd61);

        // R9 commit and lookup of same entry in one cycle
        op(1'b1, 8'd70, 1'b0, 8'd0, 8'd0, 1'b0, "R2 load");
        op(1'b0, 8'd0, 1'b1, 8'h01, 8'd70, 1'b1, "R9 red");
        op(1'b0, 8'd0, 1'b1, 8'h02, 8'd70, 1'b1, "R9 grn");
        op(1'b0, 8'd0, 1'b1, 8'h03, 8'd70, 1'b1, "R9 bypass");
        chk("R9 value", {8'd0, lk_rgb}, 32'h00010203);

        // Random mix, R3 R4 R5 R6 R7 R8 R9
        for (int i = 0; i < 3000; i++) begin
            logic iw, dw;
            logic [7:0] la;
            mode8 = 1'($urandom);
            shift_en = ($urandom % 4) == 0;
            attr_ctl_a = (($urandom % 5) == 0) ? 8'h02 : 8'($urandom) & 8'hFD;
            attr_ctl_b = (($urandom % 5) == 0) ? 8'h80 : 8'($urandom) & 8'h7F;
            iw = ($urandom % 10) == 0;
            dw = ($urandom % 8) != 0;
            la = (($urandom % 2) == 0) ? m_idx : 8'($urandom);
            op(iw, 8'($urandom), dw, 8'($urandom), la, 1'b1, "R3 R9 random");
        end

        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule